// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block sits between a host-side command register and an abstract command/response engine of a memory-card host controller. Software writes one command word and a 32-bit argument. The sequencer then runs one to three engine transactions in a fixed order:

- an application-command prefix, when the word asks for one;
- the requested command;
- a stop command, when a multi-block transfer has moved its programmed number of blocks and auto-stop is enabled.

Each engine transaction is a start pulse that carries the index, argument, response kind and data attributes. The engine answers with a done pulse, which may come with a timeout or a CRC/format error.

The sequencer can pick the response kind itself from a table of standard command indices. It also refuses a command word that is inconsistent or that arrives while a command is still running. The serial shifting of the command line, the CRC generation and the data lines are outside this block. For the stop command, the data path reports each finished block with a one-cycle tick.

Top module: `sd_cmd_seq`

## Requirements
- R1: The command word has these fields: index in bits 5:0, command kind in bits 7:6, response code in bits 10:8, data flag in bit 11, direction in bit 12 (1 = read) and multi-block in bit 13. When the response code is not 0 and the word is accepted, the engine receives the index, the argument and the response code unchanged.
- R2: Response code 0 means automatic, and the table then supplies the response kind and data attributes. The response codes are 3 = none, 4 = 48-bit, 5 = 48-bit with busy, 6 = 136-bit and 7 = 48-bit without CRC check. The table gives:
  - index 0: none;
  - indices 2 and 9: 136-bit;
  - indices 7 and 12: 48-bit with busy;
  - indices 17 and 18: 48-bit with a read data phase;
  - indices 24 and 25: 48-bit with a write data phase;
  - indices 18 and 25: multi-block;
  - every other index: 48-bit with no data.
- R3: In automatic mode, bits 13:11 of the word have no effect on what the engine receives.
- R4: Command kind 1 first issues index 55 with response code 4, no data and argument {arg[31:16], 16'h0000}. Only after that succeeds is the requested command issued. Kinds 0, 2 and 3 issue the requested command directly.
- R5: If the prefix ends with a timeout or an error, the requested command is never started. The sequence ends with a done pulse that carries that failure.
- R6: A word written while busy is high raises illegal for one cycle and starts nothing. The running sequence and its engine attributes are unaffected.
- R7: With a non-zero response code, the word is refused in any of these cases: response code 1 or 2; data flag set with response code 3; data flag set with index 12. A refused word raises illegal for one cycle, and busy stays low.
- R8: When auto-stop is sampled high at acceptance and the resolved attributes have both data and multi-block set, the sequencer issues index 12 after a successful main response. It does so once the count of block ticks since acceptance reaches blk_count (a count of 0 issues it at once). The stop command uses response code 5, argument 0 and no data.
- R9: Without auto-stop, or for single-block or no-data commands, the sequence ends at the main response.
- R10: busy rises in the cycle after acceptance and stays high until the final phase completes or fails. done is a one-cycle pulse as busy falls. done_timeout and done_error show the final phase's failure and hold until the next done. A failed main response skips the stop command.
- R11: After reset, busy, done, illegal and eng_start are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | One-cycle command write strobe |
| cmd_word | input | 14 | Command word fields |
| cmd_arg | input | ARG_W | Command argument |
| auto_stop | input | 1 | Enable automatic stop after the block count |
| blk_count | input | BLK_W | Number of blocks before the stop command |
| blk_tick | input | 1 | One data block finished |
| eng_start | output | 1 | Start pulse to the engine |
| eng_index | output | 6 | Index of the transaction being issued |
| eng_arg | output | ARG_W | Argument of the transaction |
| eng_rsp | output | 3 | Resolved response code (3..7) |
| eng_data | output | 1 | Transaction has a data phase |
| eng_rd | output | 1 | Data phase reads from the card |
| eng_multi | output | 1 | Data phase is multi-block |
| eng_done | input | 1 | Engine finished the transaction |
| eng_timeout | input | 1 | Engine saw a response timeout (valid with eng_done) |
| eng_crc_err | input | 1 | Engine saw a CRC or format error (valid with eng_done) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (pulse) |
| done_timeout | output | 1 | Final phase timed out |
| done_error | output | 1 | Final phase had an error |
| illegal | output | 1 | Command word refused (pulse) |

## Verification
The assertions assume that the engine raises eng_done only while a transaction is outstanding and never in the same cycle as its eng_start. This gives at least one idle cycle between two start pulses. It also assumes that eng_timeout and eng_crc_err mean something only alongside eng_done. The bench's engine model waits for each start, holds off two cycles, and then raises done for exactly one cycle together with the failure flags it wants. Block ticks are only driven after the main response has been served, so every stop command follows a known count.

// File: rtl/sd_seq_pkg.sv
package sd_seq_pkg;

  localparam logic [5:0] IDX_APP  = 6'd55;
  localparam logic [5:0] IDX_STOP = 6'd12;

  typedef enum logic [2:0] {
    RSP_AUTO = 3'd0,
    RSP_RES1 = 3'd1,
    RSP_RES2 = 3'd2,
    RSP_NONE = 3'd3,
    RSP_S48  = 3'd4,
    RSP_S48B = 3'd5,
    RSP_L136 = 3'd6,
    RSP_S48N = 3'd7
  } rsp_e;

  typedef struct packed {
    rsp_e rsp;
    logic data;
    logic rd;
    logic multi;
  } cmd_attr_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_MAIN = 3'd2,
    ST_BLK  = 3'd3,
    ST_STOP = 3'd4
  } seq_st_e;

  // Built-in attributes for standard indices; anything unlisted is a plain 48-bit command.
  function automatic cmd_attr_t auto_attr(input logic [5:0] idx);
    cmd_attr_t a;
    a = '{rsp: RSP_S48, data: 1'b0, rd: 1'b0, multi: 1'b0};
    case (idx)
      6'd0:        a.rsp = RSP_NONE;
      6'd2, 6'd9:  a.rsp = RSP_L136;
      6'd7, 6'd12: a.rsp = RSP_S48B;
      6'd17:       begin a.data = 1'b1; a.rd = 1'b1; end
      6'd18:       begin a.data = 1'b1; a.rd = 1'b1; a.multi = 1'b1; end
      6'd24:       a.data = 1'b1;
      6'd25:       begin a.data = 1'b1; a.multi = 1'b1; end
      default:     ;
    endcase
    return a;
  endfunction

  // Consistency rule for an explicitly typed word.
  function automatic logic word_refused(input rsp_e rsp, input logic data,
                                        input logic [5:0] idx);
    logic reserved;
    reserved = (rsp == RSP_RES1) || (rsp == RSP_RES2);
    return reserved || (data && ((rsp == RSP_NONE) || (idx == IDX_STOP)));
  endfunction

endpackage

// File: rtl/sd_cmd_decode.sv
module sd_cmd_decode
  import sd_seq_pkg::*;
(
  input  logic [13:0] word,
  output cmd_attr_t   attr,
  output logic        is_app,
  output logic        bad
);

  rsp_e field_rsp;
  logic is_auto;

  assign field_rsp = rsp_e'(word[10:8]);
  assign is_auto   = (field_rsp == RSP_AUTO);
  assign is_app    = (word[7:6] == 2'b01);

  always_comb begin
    if (is_auto) begin
      attr = auto_attr(word[5:0]);
      bad  = 1'b0;
    end else begin
      attr = '{rsp: field_rsp, data: word[11], rd: word[12], multi: word[13]};
      bad  = word_refused(field_rsp, word[11], word[5:0]);
    end
  end

endmodule

// File: rtl/sd_blk_counter.sv
module sd_blk_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         reached
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clr)                      cnt_q <= '0;
    else if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign reached = (cnt_q >= limit);

endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
  import sd_seq_pkg::*;
#(
  parameter int ARG_W = 32,
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [13:0]      cmd_word,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             auto_stop,
  input  logic [BLK_W-1:0] blk_count,
  input  logic             blk_tick,
  output logic             eng_start,
  output logic [5:0]       eng_index,
  output logic [ARG_W-1:0] eng_arg,
  output logic [2:0]       eng_rsp,
  output logic             eng_data,
  output logic             eng_rd,
  output logic             eng_multi,
  input  logic             eng_done,
  input  logic             eng_timeout,
  input  logic             eng_crc_err,
  output logic             busy,
  output logic             done,
  output logic             done_timeout,
  output logic             done_error,
  output logic             illegal
);

  localparam int HALF_W = ARG_W / 2;

  cmd_attr_t dec_attr;
  logic      dec_app, dec_bad;

  sd_cmd_decode u_dec (
    .word   (cmd_word),
    .attr   (dec_attr),
    .is_app (dec_app),
    .bad    (dec_bad)
  );

  seq_st_e          st_q, st_d;
  logic [5:0]       lat_idx;
  logic [ARG_W-1:0] lat_arg;
  cmd_attr_t        lat_attr;
  logic             lat_stop;
  logic             start_q, start_d;
  logic             fin;
  logic             done_q, tmo_q, err_q, ill_q;
  logic             blk_reached;

  // Named internal events, used by the bound checker.
  logic accept_ev, reject_ev, eng_fail, pre_ok_ev, stop_go_ev;

  assign accept_ev  = cmd_wr && (st_q == ST_IDLE) && !dec_bad;
  assign reject_ev  = cmd_wr && ((st_q != ST_IDLE) || dec_bad);
  assign eng_fail   = eng_timeout || eng_crc_err;
  assign pre_ok_ev  = (st_q == ST_PRE) && eng_done && !eng_fail;
  assign stop_go_ev = (st_q == ST_BLK) && blk_reached;

  sd_blk_counter #(.W(BLK_W)) u_blk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept_ev),
    .tick    (blk_tick && (st_q != ST_IDLE)),
    .limit   (blk_count),
    .reached (blk_reached)
  );

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    fin     = 1'b0;
    case (st_q)
      ST_IDLE: if (accept_ev) begin
        st_d    = dec_app ? ST_PRE : ST_MAIN;
        start_d = 1'b1;
      end
      ST_PRE: if (eng_done) begin
        if (eng_fail) begin st_d = ST_IDLE; fin = 1'b1; end
        else begin st_d = ST_MAIN; start_d = 1'b1; end
      end
      ST_MAIN: if (eng_done) begin
        if (eng_fail || !lat_stop) begin st_d = ST_IDLE; fin = 1'b1; end
        else st_d = ST_BLK;
      end
      ST_BLK: if (blk_reached) begin
        st_d    = ST_STOP;
        start_d = 1'b1;
      end
      ST_STOP: if (eng_done) begin st_d = ST_IDLE; fin = 1'b1; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      start_q  <= 1'b0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
      err_q    <= 1'b0;
      ill_q    <= 1'b0;
      lat_idx  <= '0;
      lat_arg  <= '0;
      lat_attr <= '{rsp: RSP_NONE, data: 1'b0, rd: 1'b0, multi: 1'b0};
      lat_stop <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      done_q  <= fin;
      ill_q   <= reject_ev;
      if (fin) begin
        tmo_q <= eng_timeout;
        err_q <= eng_crc_err;
      end
      if (accept_ev) begin
        lat_idx  <= cmd_word[5:0];
        lat_arg  <= cmd_arg;
        lat_attr <= dec_attr;
        lat_stop <= auto_stop && dec_attr.data && dec_attr.multi;
      end
    end
  end

  // Engine-side view of the current phase.
  always_comb begin
    case (st_q)
      ST_PRE: begin
        eng_index = IDX_APP;
        eng_arg   = {lat_arg[ARG_W-1:HALF_W], {HALF_W{1'b0}}};
        eng_rsp   = RSP_S48;
        eng_data  = 1'b0;
        eng_rd    = 1'b0;
        eng_multi = 1'b0;
      end
      ST_STOP: begin
        eng_index = IDX_STOP;
        eng_arg   = '0;
        eng_rsp   = RSP_S48B;
        eng_data  = 1'b0;
        eng_rd    = 1'b0;
        eng_multi = 1'b0;
      end
      default: begin
        eng_index = lat_idx;
        eng_arg   = lat_arg;
        eng_rsp   = lat_attr.rsp;
        eng_data  = lat_attr.data;
        eng_rd    = lat_attr.rd && lat_attr.data;
        eng_multi = lat_attr.multi && lat_attr.data;
      end
    endcase
  end

  assign eng_start    = start_q;
  assign busy         = (st_q != ST_IDLE);
  assign done         = done_q;
  assign done_timeout = tmo_q;
  assign done_error   = err_q;
  assign illegal      = ill_q;

endmodule

// File: rtl/sd_cmd_seq_chk.sv
module sd_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       illegal,
  input logic       eng_start,
  input logic [5:0] eng_index,
  input logic [2:0] eng_rsp,
  input logic       pre_ok_ev,
  input logic       stop_go_ev
);

  // R10
  start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);

  // R10
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  illegal_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !eng_start);

  // R4
  prefix_then_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_ok_ev |=> (eng_start && eng_index != 6'd55));

  // R8
  stop_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_go_ev |=> (eng_start && eng_index == 6'd12 && eng_rsp == 3'd5));

  // R2
  rsp_resolved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (eng_rsp >= 3'd3));

endmodule

bind sd_cmd_seq sd_cmd_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .illegal    (illegal),
  .eng_start  (eng_start),
  .eng_index  (eng_index),
  .eng_rsp    (eng_rsp),
  .pre_ok_ev  (pre_ok_ev),
  .stop_go_ev (stop_go_ev)
);

// File: tb/sd_cmd_seq_tb.sv
module sd_cmd_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [13:0] cmd_word = '0;
  logic [31:0] cmd_arg = '0;
  logic        auto_stop = 1'b0;
  logic [15:0] blk_count = '0;
  logic        blk_tick = 1'b0;
  logic        eng_start, eng_data, eng_rd, eng_multi;
  logic [5:0]  eng_index;
  logic [31:0] eng_arg;
  logic [2:0]  eng_rsp;
  logic        eng_done = 1'b0, eng_timeout = 1'b0, eng_crc_err = 1'b0;
  logic        busy, done, done_timeout, done_error, illegal;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sd_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
    .auto_stop(auto_stop), .blk_count(blk_count), .blk_tick(blk_tick),
    .eng_start(eng_start), .eng_index(eng_index), .eng_arg(eng_arg), .eng_rsp(eng_rsp),
    .eng_data(eng_data), .eng_rd(eng_rd), .eng_multi(eng_multi),
    .eng_done(eng_done), .eng_timeout(eng_timeout), .eng_crc_err(eng_crc_err),
    .busy(busy), .done(done), .done_timeout(done_timeout), .done_error(done_error),
    .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected {rsp[2:0], data, rd, multi} for automatic mode.
  function automatic logic [5:0] exp_auto(input int idx);
    logic [2:0] r;
    logic d, rd, m;
    d  = (idx == 17) || (idx == 18) || (idx == 24) || (idx == 25);
    rd = (idx == 17) || (idx == 18);
    m  = (idx == 18) || (idx == 25);
    if (idx == 0) r = 3'd3;
    else if (idx == 2 || idx == 9) r = 3'd6;
    else if (idx == 7 || idx == 12) r = 3'd5;
    else r = 3'd4;
    return {r, d, rd, m};
  endfunction

  function automatic logic [13:0] mk(input logic [5:0] idx, input logic [1:0] typ,
                                     input logic [2:0] rsp, input logic d,
                                     input logic rd, input logic m);
    return {m, rd, d, rsp, typ, idx};
  endfunction

  task automatic issue(input logic [13:0] w, input logic [31:0] a);
    @(negedge clk);
    cmd_word = w; cmd_arg = a; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic take(input logic [5:0] idx, input logic [5:0] att,
                      input logic [31:0] a, input string req);
    int waited = 0;
    while (!eng_start && waited < 20) begin @(negedge clk); waited++; end
    chk(eng_start === 1'b1, req, "start", 64'(eng_start), 64'd1);
    chk({eng_index, eng_rsp, eng_data, eng_rd, eng_multi} === {idx, att}, req, "attr",
        64'({eng_index, eng_rsp, eng_data, eng_rd, eng_multi}), 64'({idx, att}));
    chk(eng_arg === a, req, "arg", 64'(eng_arg), 64'(a));
  endtask

  task automatic finish_phase(input logic tmo, input logic err);
    @(negedge clk); @(negedge clk);
    eng_timeout = tmo; eng_crc_err = err; eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0; eng_timeout = 1'b0; eng_crc_err = 1'b0;
  endtask

  task automatic expect_end(input logic tmo, input logic err, input string req);
    chk(done === 1'b1 && busy === 1'b0, req, "done/busy", 64'({done, busy}), 64'b10);
    chk({done_timeout, done_error} === {tmo, err}, req, "fail flags",
        64'({done_timeout, done_error}), 64'({tmo, err}));
    @(negedge clk);
    chk(done === 1'b0, "R10", "done pulse width", 64'(done), 64'd0);
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (eng_start) seen = 1'b1;
    end
    chk(!seen, req, "no start", 64'(seen), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk({busy, done, illegal, eng_start} === 4'b0, "R11", "reset outputs",
        64'({busy, done, illegal, eng_start}), 64'd0);

    // R2 / R3: automatic sweep over every index, junk in bits 13:11
    for (int i = 0; i < 64; i++) begin
      logic [5:0] ix;
      ix = 6'(i);
      issue(mk(ix, 2'b00, 3'd0, ix[0], ix[1], ix[2]), 32'h1000_0000 + 32'(i));
      take(ix, exp_auto(i), 32'h1000_0000 + 32'(i), "R2 R3");
      finish_phase(1'b0, 1'b0);
      expect_end(1'b0, 1'b0, "R9");
    end

    // R1 / R7: explicit response codes, data flag, index 5 and 12
    for (int r = 1; r < 8; r++) begin
      for (int d = 0; d < 2; d++) begin
        for (int k = 0; k < 2; k++) begin
          logic [5:0] ix;
          bit refuse;
          ix = (k == 0) ? 6'd5 : 6'd12;
          refuse = (r == 1) || (r == 2) || ((d == 1) && ((r == 3) || (ix == 6'd12)));
          issue(mk(ix, 2'b00, 3'(r), 1'(d), 1'b1, 1'b0), 32'hA5A5_0000 + 32'(r));
          if (refuse) begin
            chk(illegal === 1'b1 && eng_start === 1'b0 && busy === 1'b0, "R7",
                "refused word", 64'({illegal, eng_start, busy}), 64'b100);
            @(negedge clk);
          end else begin
            chk(illegal === 1'b0, "R1", "no illegal", 64'(illegal), 64'd0);
            take(ix, {3'(r), 1'(d), 1'(d), 1'b0}, 32'hA5A5_0000 + 32'(r), "R1");
            finish_phase(1'b0, 1'b0);
            expect_end(1'b0, 1'b0, "R1");
          end
        end
      end
    end

    // R4: command kinds
    for (int t = 0; t < 4; t++) begin
      issue(mk(6'd41, 2'(t), 3'd0, 1'b0, 1'b0, 1'b0), 32'hBEEF_1234);
      if (t == 1) begin
        take(6'd55, 6'b100_000, 32'hBEEF_0000, "R4");
        finish_phase(1'b0, 1'b0);
        chk(busy === 1'b1, "R10", "busy between phases", 64'(busy), 64'd1);
      end
      take(6'd41, 6'b100_000, 32'hBEEF_1234, "R4");
      finish_phase(1'b0, 1'b0);
      expect_end(1'b0, 1'b0, "R4");
    end

    // R5: failed prefix skips the main command
    for (int f = 0; f < 2; f++) begin
      issue(mk(6'd13, 2'b01, 3'd0, 1'b0, 1'b0, 1'b0), 32'h0007_0000);
      take(6'd55, 6'b100_000, 32'h0007_0000, "R5");
      finish_phase(1'(f == 0), 1'(f == 1));
      expect_end(1'(f == 0), 1'(f == 1), "R5");
      quiet(6, "R5");
    end

    // R6: write while busy is refused, running command unaffected
    issue(mk(6'd17, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0), 32'h0000_0200);
    take(6'd17, exp_auto(17), 32'h0000_0200, "R6");
    issue(mk(6'd24, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0), 32'h0000_0300);
    chk(illegal === 1'b1 && eng_start === 1'b0 && busy === 1'b1, "R6", "busy write",
        64'({illegal, eng_start, busy}), 64'b101);
    chk({eng_index, eng_arg} === {6'd17, 32'h0000_0200}, "R6", "attrs kept",
        64'({eng_index, eng_arg}), 64'({6'd17, 32'h0000_0200}));
    finish_phase(1'b0, 1'b0);
    expect_end(1'b0, 1'b0, "R6");
    quiet(4, "R6");

    // R8: auto stop after block counts 0, 1, 3 (auto index 18)
    auto_stop = 1'b1;
    for (int n = 0; n < 4; n++) begin
      if (n == 2) continue;
      blk_count = 16'(n);
      issue(mk(6'd18, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0), 32'h0000_4000);
      take(6'd18, exp_auto(18), 32'h0000_4000, "R8");
      finish_phase(1'b0, 1'b0);
      for (int b = 0; b < n; b++) begin
        if (b == n - 1) quiet(3, "R8");
        blk_tick = 1'b1; @(negedge clk); blk_tick = 1'b0;
      end
      take(6'd12, 6'b101_000, 32'h0, "R8");
      finish_phase(1'b0, 1'b0);
      expect_end(1'b0, 1'b0, "R8");
    end

    // R8: explicit multi-block write, 2 blocks, stop fails with error
    blk_count = 16'd2;
    issue(mk(6'd25, 2'b00, 3'd4, 1'b1, 1'b0, 1'b1), 32'h0000_5000);
    take(6'd25, 6'b100_101, 32'h0000_5000, "R8");
    finish_phase(1'b0, 1'b0);
    for (int b = 0; b < 2; b++) begin
      blk_tick = 1'b1; @(negedge clk); blk_tick = 1'b0;
    end
    take(6'd12, 6'b101_000, 32'h0, "R8");
    finish_phase(1'b0, 1'b1);
    expect_end(1'b0, 1'b1, "R10");

    // R10: failed main response skips the stop command
    blk_count = 16'd0;
    issue(mk(6'd18, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0), 32'h0000_6000);
    take(6'd18, exp_auto(18), 32'h0000_6000, "R10");
    finish_phase(1'b1, 1'b0);
    expect_end(1'b1, 1'b0, "R10");
    quiet(5, "R10");

    // R9: multi-block without auto-stop ends at the main response
    auto_stop = 1'b0;
    issue(mk(6'd18, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0), 32'h0000_7000);
    take(6'd18, exp_auto(18), 32'h0000_7000, "R9");
    finish_phase(1'b0, 1'b0);
    expect_end(1'b0, 1'b0, "R9");
    quiet(5, "R9");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule